// File: doc/BRIEF.md
# Amplifier Configuration Front-Panel Controller

This block keeps the working configuration of a programmable-gain amplifier: a gain step, the input coupling, the input source and the shield connection. The gain moves along a seven-step 1-2-5 ladder. Single-cycle pulses from front-panel buttons step it up or down, and it stops at either end. A host port can also write the whole configuration in one cycle. It checks the values first and rejects any write that is out of range.

Every real change of the configuration starts a reload of an external chain of serial shift registers. The block shifts out one 16-bit control word on a divided serial clock and then strobes the latch. A change that arrives during a reload is held back. It produces exactly one more reload once the current one is complete, and that reload carries the newest configuration. One output per gain step drives the front-panel indicator LEDs, and exactly one of them is lit at a time.

Top module: `amp_cfg_ctrl`

## Requirements
- R1: The gain is held as an index from 0 to 6, standing for gains 1, 2, 5, 10, 20, 50 and 100 in that order. A `btn_up` pulse without `btn_down` raises the index by one, and a `btn_down` pulse without `btn_up` lowers it by one. The new index appears on `gain_idx` after the next clock edge.
- R2: An up request at index 6 leaves the configuration unchanged, and so does a down request at index 0. Up and down in the same cycle also leave it unchanged. None of these cases starts a reload.
- R3: A `host_wr` cycle loads gain, coupling, source and shield together when `host_gain` is at most 6 and `host_src` is at most 2. A host write takes priority over button pulses in the same cycle.
- R4: A host write with `host_gain` above 6, or with `host_src` equal to 3, leaves the whole configuration unchanged. It raises `host_err` for exactly the one cycle that follows the write.
- R5: `gain_led` is one-hot, with bit k set when the gain index is k.
- R6: The control word has the one-hot gain in bits [15:9] (bit 9+k for index k). Bit 8 is coupling (1 = AC, 0 = DC). Bits [7:6] are the source (0 = A, 1 = A minus B, 2 = ground). Bit 5 is the shield (1 = grounded, 0 = floating). Bits [4:0] are zero.
- R7: The word goes out MSB first. `sr_data` is stable while `sr_clk` is high, and the receiver takes it on the rising edge. Each half of a serial clock period lasts `SCLK_HALF` system clocks.
- R8: After the sixteenth bit, `sr_latch` is high for one serial clock period (2*`SCLK_HALF` cycles) while `sr_clk` stays low.
- R9: `busy` stays high from the start of a reload until the latch strobe ends, for 34*`SCLK_HALF` cycles in total.
- R10: Reset loads gain index 0, DC coupling, source A and a floating shield (word 16'h0200), and one reload then starts on its own.
- R11: Any number of changes made during a reload produce exactly one further reload, which carries the latest configuration. A host write that matches the current configuration starts no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_up | input | 1 | One-cycle gain-up request |
| btn_down | input | 1 | One-cycle gain-down request |
| host_wr | input | 1 | Host configuration write strobe |
| host_gain | input | 3 | Host gain index |
| host_ac | input | 1 | Host coupling, 1 = AC |
| host_src | input | 2 | Host source code |
| host_shield | input | 1 | Host shield, 1 = grounded |
| host_err | output | 1 | One-cycle rejected-write pulse |
| gain_idx | output | 3 | Current gain index |
| gain_led | output | 7 | One-hot gain indicators |
| sr_clk | output | 1 | Serial clock to shift registers |
| sr_data | output | 1 | Serial data to shift registers |
| sr_latch | output | 1 | Latch strobe to shift registers |
| busy | output | 1 | Reload in progress |

## Verification
The assertions check the following on every cycle:
- the gain index stays in range and moves by at most one step unless the host writes;
- the gain saturates at both ends;
- the LEDs stay one-hot;
- an error pulse only follows a write;
- serial data holds while the clock is high;
- the latch and the clock only appear while busy, and the clock is low during the latch.

The bench scenarios cover what needs a whole transaction to see. They rebuild each shifted word from the serial pins and compare it with the expected configuration. They measure the lengths of the busy window and the latch strobe. They count reloads, to show that saturated, rejected, identical and contradictory requests start none and that a burst of changes during a reload produces exactly one more.

// File: rtl/amp_cfg_pkg.sv
package amp_cfg_pkg;

    localparam int GAIN_STEPS = 7;
    localparam int GAIN_W     = 3;
    localparam int WORD_W     = 16;
    localparam int PAD_W      = WORD_W - GAIN_STEPS - 4;

    typedef enum logic [1:0] {
        SRC_A    = 2'd0,
        SRC_DIFF = 2'd1,
        SRC_GND  = 2'd2
    } src_sel_e;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              ac;
        src_sel_e          src;
        logic              shield_gnd;
    } amp_cfg_t;

    localparam amp_cfg_t CFG_DEFAULT = '{
        gain:       '0,
        ac:         1'b0,
        src:        SRC_A,
        shield_gnd: 1'b0
    };

    function automatic logic [WORD_W-1:0] cfg_to_word(amp_cfg_t c);
        logic [GAIN_STEPS-1:0] oh;
        oh = GAIN_STEPS'(1) << c.gain;
        return {oh, c.ac, c.src, c.shield_gnd, {PAD_W{1'b0}}};
    endfunction

endpackage

// File: rtl/amp_gain_step.sv
module amp_gain_step #(
    parameter int STEPS = 7,
    localparam int IW   = $clog2(STEPS)
) (
    input  logic [IW-1:0] cur,
    input  logic          up,
    input  logic          down,
    output logic [IW-1:0] nxt
);
    localparam logic [IW-1:0] TOP = IW'(STEPS - 1);

    always_comb begin
        nxt = cur;
        if (up && !down && cur != TOP) begin
            nxt = cur + 1'b1;
        end else if (down && !up && cur != '0) begin
            nxt = cur - 1'b1;
        end
    end
endmodule

// File: rtl/amp_cfg_shifter.sv
module amp_cfg_shifter #(
    parameter int WORD_W   = 16,
    parameter int HALF_DIV = 4,
    localparam int CNT_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1,
    localparam int BIT_W   = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              sclk,
    output logic              sdata,
    output logic              slatch,
    output logic              busy
);
    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_LATCH} sh_state_e;

    typedef struct packed {
        sh_state_e         st;
        logic [WORD_W-1:0] sreg;
        logic [BIT_W-1:0]  bit_n;
        logic [CNT_W-1:0]  cnt;
        logic              phase;
    } sh_t;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    sh_t s_d, s_q;
    logic tick;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt == CNT_LAST);
        if (s_q.st != ST_IDLE) begin
            s_d.cnt = tick ? '0 : s_q.cnt + 1'b1;
        end
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st    = ST_SHIFT;
                    s_d.sreg  = word;
                    s_d.bit_n = '0;
                    s_d.cnt   = '0;
                    s_d.phase = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    s_d.phase = ~s_q.phase;
                    if (s_q.phase) begin
                        if (s_q.bit_n == BIT_LAST) begin
                            s_d.st = ST_LATCH;
                        end else begin
                            s_d.bit_n = s_q.bit_n + 1'b1;
                            s_d.sreg  = {s_q.sreg[WORD_W-2:0], 1'b0};
                        end
                    end
                end
            end
            ST_LATCH: begin
                if (tick) begin
                    s_d.phase = ~s_q.phase;
                    if (s_q.phase) s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, sreg: '0, bit_n: '0, cnt: '0, phase: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk   = (s_q.st == ST_SHIFT) && s_q.phase;
    assign sdata  = (s_q.st == ST_SHIFT) && s_q.sreg[WORD_W-1];
    assign slatch = (s_q.st == ST_LATCH);
    assign busy   = (s_q.st != ST_IDLE);
endmodule

// File: rtl/amp_cfg_ctrl.sv
module amp_cfg_ctrl
    import amp_cfg_pkg::*;
#(
    parameter int SCLK_HALF = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  btn_up,
    input  logic                  btn_down,
    input  logic                  host_wr,
    input  logic [GAIN_W-1:0]     host_gain,
    input  logic                  host_ac,
    input  logic [1:0]            host_src,
    input  logic                  host_shield,
    output logic                  host_err,
    output logic [GAIN_W-1:0]     gain_idx,
    output logic [GAIN_STEPS-1:0] gain_led,
    output logic                  sr_clk,
    output logic                  sr_data,
    output logic                  sr_latch,
    output logic                  busy
);
    localparam logic [GAIN_W-1:0] GAIN_MAX = GAIN_W'(GAIN_STEPS - 1);

    typedef struct packed {
        amp_cfg_t cfg;
        logic     pending;
        logic     err;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [GAIN_W-1:0] gain_next;
    amp_cfg_t          cfg_new;
    logic              host_ok;
    logic              start_shift;
    logic              sh_busy;

    amp_gain_step #(.STEPS(GAIN_STEPS)) u_step (
        .cur  (st_q.cfg.gain),
        .up   (btn_up),
        .down (btn_down),
        .nxt  (gain_next)
    );

    always_comb begin
        st_d        = st_q;
        host_ok     = (host_gain <= GAIN_MAX) && (host_src != 2'd3);
        cfg_new     = st_q.cfg;
        st_d.err    = 1'b0;
        if (host_wr) begin
            if (host_ok) begin
                cfg_new.gain       = host_gain;
                cfg_new.ac         = host_ac;
                cfg_new.src        = src_sel_e'(host_src);
                cfg_new.shield_gnd = host_shield;
            end else begin
                st_d.err = 1'b1;
            end
        end else begin
            cfg_new.gain = gain_next;
        end
        start_shift  = st_q.pending && !sh_busy;
        st_d.cfg     = cfg_new;
        st_d.pending = (st_q.pending && !start_shift) || (cfg_new != st_q.cfg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: CFG_DEFAULT, pending: 1'b1, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    amp_cfg_shifter #(.WORD_W(WORD_W), .HALF_DIV(SCLK_HALF)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_shift),
        .word   (cfg_to_word(st_q.cfg)),
        .sclk   (sr_clk),
        .sdata  (sr_data),
        .slatch (sr_latch),
        .busy   (sh_busy)
    );

    for (genvar k = 0; k < GAIN_STEPS; k++) begin : g_led
        assign gain_led[k] = (st_q.cfg.gain == GAIN_W'(k));
    end

    assign gain_idx = st_q.cfg.gain;
    assign host_err = st_q.err;
    assign busy     = sh_busy;
endmodule

// File: rtl/amp_cfg_ctrl_sva.sv
module amp_cfg_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       btn_up,
    input logic       btn_down,
    input logic       host_wr,
    input logic       host_err,
    input logic [2:0] gain_idx,
    input logic [6:0] gain_led,
    input logic       sr_clk,
    input logic       sr_data,
    input logic       sr_latch,
    input logic       busy
);
    a_r1_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        gain_idx <= 3'd6);

    a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> (int'(gain_idx) - int'($past(gain_idx)) <= 1) &&
                     (int'($past(gain_idx)) - int'(gain_idx) <= 1));

    a_r2_top_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_up && !btn_down && !host_wr && gain_idx == 3'd6) |=> gain_idx == 3'd6);

    a_r2_bottom_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_down && !btn_up && !host_wr && gain_idx == 3'd0) |=> gain_idx == 3'd0);

    a_r4_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> $past(host_wr));

    a_r5_led_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gain_led) == 1);

    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sr_clk |-> $stable(sr_data));

    a_r8_latch_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        sr_latch |-> (!sr_clk && busy));

    a_r9_clock_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sr_clk |-> busy);
endmodule

bind amp_cfg_ctrl amp_cfg_ctrl_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .btn_up   (btn_up),
    .btn_down (btn_down),
    .host_wr  (host_wr),
    .host_err (host_err),
    .gain_idx (gain_idx),
    .gain_led (gain_led),
    .sr_clk   (sr_clk),
    .sr_data  (sr_data),
    .sr_latch (sr_latch),
    .busy     (busy)
);

// File: tb/amp_cfg_ctrl_test.sv
module amp_cfg_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int BUSY_LEN   = 34 * HALF;
    localparam int LATCH_LEN  = 2 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_up = 1'b0, btn_down = 1'b0, host_wr = 1'b0;
    logic [2:0] host_gain = '0;
    logic host_ac = 1'b0, host_shield = 1'b0;
    logic [1:0] host_src = '0;
    logic host_err, sr_clk, sr_data, sr_latch, busy;
    logic [2:0] gain_idx;
    logic [6:0] gain_led;

    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amp_cfg_ctrl #(.SCLK_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .btn_up(btn_up), .btn_down(btn_down),
        .host_wr(host_wr), .host_gain(host_gain), .host_ac(host_ac),
        .host_src(host_src), .host_shield(host_shield), .host_err(host_err),
        .gain_idx(gain_idx), .gain_led(gain_led), .sr_clk(sr_clk),
        .sr_data(sr_data), .sr_latch(sr_latch), .busy(busy)
    );

    // serial capture monitor
    logic [15:0] cap = '0, last_word = '0;
    int nbits = 0, last_bits = 0, shifts = 0;
    int latch_run = 0, last_latch = 0, busy_run = 0, last_busy = 0;
    logic p_clk = 1'b0, p_latch = 1'b0, p_busy = 1'b0;

    always @(negedge clk) begin
        if (sr_clk && !p_clk) begin
            cap = {cap[14:0], sr_data};
            nbits++;
        end
        if (sr_latch && !p_latch) begin
            last_word = cap;
            last_bits = nbits;
            nbits = 0;
            shifts++;
        end
        if (sr_latch) latch_run++;
        if (!sr_latch && p_latch) begin last_latch = latch_run; latch_run = 0; end
        if (busy) busy_run++;
        if (!busy && p_busy) begin last_busy = busy_run; busy_run = 0; end
        p_clk = sr_clk; p_latch = sr_latch; p_busy = busy;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int g, input bit ac,
                                              input int src, input bit sh);
        logic [6:0] oh;
        oh = 7'(1) << g;
        return {oh, ac, 2'(src), sh, 5'b0};
    endfunction

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (busy) quiet = 0; else quiet++;
        end
    endtask

    task automatic pulse(input bit up, input bit dn);
        @(negedge clk);
        btn_up = up; btn_down = dn;
        @(negedge clk);
        btn_up = 1'b0; btn_down = 1'b0;
    endtask

    task automatic host_write(input int g, input bit ac, input int src, input bit sh);
        @(negedge clk);
        host_wr = 1'b1; host_gain = 3'(g); host_ac = ac;
        host_src = 2'(src); host_shield = sh;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 reset gain", int'(gain_idx), 0);
        check("R5 reset led", int'(gain_led), 1);
        @(negedge clk); rst_n = 1'b1;
        wait_idle();
        check("R10 one reload after reset", shifts, 1);
        check("R10 default word", int'(last_word), 16'h0200);
        check("R7 bit count", last_bits, 16);
        check("R9 busy length", last_busy, BUSY_LEN);
        check("R8 latch length", last_latch, LATCH_LEN);
    endtask

    task automatic t_ladder();
        for (int k = 1; k <= 6; k++) begin
            pulse(1'b1, 1'b0);
            check("R1 step up index", int'(gain_idx), k);
            check("R5 led follows index", int'(gain_led), 1 << k);
            wait_idle();
            check("R6 word after step up", int'(last_word), int'(exp_word(k, 0, 0, 0)));
        end
    endtask

    task automatic t_saturate();
        int s0;
        s0 = shifts;
        pulse(1'b1, 1'b0);
        wait_idle();
        check("R2 up at top", int'(gain_idx), 6);
        check("R2 no reload at top", shifts, s0);
        for (int k = 5; k >= 0; k--) begin
            pulse(1'b0, 1'b1);
            check("R1 step down index", int'(gain_idx), k);
        end
        wait_idle();
        s0 = shifts;
        pulse(1'b0, 1'b1);
        wait_idle();
        check("R2 down at bottom", int'(gain_idx), 0);
        check("R2 no reload at bottom", shifts, s0);
        pulse(1'b1, 1'b1);
        wait_idle();
        check("R2 both buttons ignored", int'(gain_idx), 0);
        check("R2 both buttons no reload", shifts, s0);
    endtask

    task automatic t_host();
        int s0;
        host_write(4, 1'b1, 1, 1'b1);
        check("R3 host gain", int'(gain_idx), 4);
        check("R4 no error on valid write", int'(host_err), 0);
        wait_idle();
        check("R3 R6 host word", int'(last_word), int'(exp_word(4, 1, 1, 1)));
        s0 = shifts;
        @(negedge clk);
        host_wr = 1'b1; host_gain = 3'd7; host_src = 2'd0;
        @(negedge clk);
        host_wr = 1'b0;
        check("R4 error pulse", int'(host_err), 1);
        check("R4 gain kept", int'(gain_idx), 4);
        @(negedge clk);
        check("R4 error single cycle", int'(host_err), 0);
        host_write(2, 1'b0, 3, 1'b0);
        check("R4 bad source error", int'(host_err), 1);
        wait_idle();
        check("R4 no reload on reject", shifts, s0);
        check("R4 word unchanged", int'(last_word), int'(exp_word(4, 1, 1, 1)));
        host_write(4, 1'b1, 1, 1'b1);
        wait_idle();
        check("R11 identical write no reload", shifts, s0);
        @(negedge clk);
        host_wr = 1'b1; host_gain = 3'd2; host_ac = 1'b0; host_src = 2'd2; host_shield = 1'b0;
        btn_up = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; btn_up = 1'b0;
        check("R3 host beats button", int'(gain_idx), 2);
        wait_idle();
        check("R3 ground source word", int'(last_word), int'(exp_word(2, 0, 2, 0)));
    endtask

    task automatic t_burst();
        int s0;
        s0 = shifts;
        pulse(1'b1, 1'b0);
        repeat (10) @(negedge clk);
        check("R9 busy during reload", int'(busy), 1);
        pulse(1'b1, 1'b0);
        repeat (5) @(negedge clk);
        pulse(1'b1, 1'b0);
        wait_idle();
        check("R11 exactly one extra reload", shifts, s0 + 2);
        check("R11 latest config shifted", int'(last_word), int'(exp_word(5, 0, 2, 0)));
        check("R9 busy length repeat", last_busy, BUSY_LEN);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ladder();
        t_saturate();
        t_host();
        t_burst();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule